// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block watches a single load/store request port between a compute unit and the buffer that serves it. It drives nothing on that port. It keeps its own model of the transaction in flight and compares it with what the port shows. The model tracks the idle state, an open load or store, and the one-cycle tail that follows a store strobe. Whenever the traffic breaks one of the port's handshake rules, the monitor raises the bit assigned to that rule.

The protocol is not fire-and-forget. Busy must rise in the cycle a request appears. For a load it falls together with the load-data pulse, and for an exception it falls together with the exception pulse. For a store it falls only one cycle after the store-data strobe. Once the address is marked valid, it must stay valid and stay constant for the rest of the transaction. An acknowledged address can no longer end in an exception.

Every violation sets its bit in a sticky code vector and also sets a summary flag. Both stay set until a synchronous clear pulse or a reset. Data values and memory behaviour are not examined.

Top module: `ldst_port_monitor`

## Requirements
- R1: Load request and store request high in the same cycle sets code bit 0.
- R2: A rising edge of the combined request (load or store, low in the previous cycle) while a transaction is open or in its store tail sets code bit 1.
- R3: Observed busy must equal the expected busy, or code bit 2 is set. Expected busy is high from the cycle a request edge opens a transaction while idle. It is low in the cycle of a load-data pulse that completes a load, low in the cycle of an exception, and still high in the store-strobe cycle. It is low in the tail cycle after a store strobe and low while idle.
- R4: Once address valid has been seen during an open transaction, a later open cycle with address valid low or a changed address value sets code bit 3.
- R5: Address acknowledge high in two consecutive cycles sets code bit 4. Address exception high in two consecutive cycles sets code bit 5.
- R6: An exception during an open transaction whose address was already acknowledged, or in the same cycle as an acknowledge, sets code bit 6.
- R7: An acknowledge or exception while no transaction is open (idle or store tail) sets code bit 7.
- R8: A load-data pulse outside an open load, or in two consecutive cycles, sets code bit 8.
- R9: A store strobe outside an open store, before an acknowledge seen in an earlier cycle, or in two consecutive cycles, sets code bit 9.
- R10: Code bits appear in the cycle after the violating cycle and stay set until a clear pulse. A clear with no violation in that cycle empties the code. A violation in the clear cycle is still recorded. The summary flag is high exactly when any code bit is set.
- R11: Reset empties the code, lowers the summary flag and returns the monitor to idle, forgetting any open transaction.
- R12: Compliant load, store and exception transactions leave the code empty. This holds for late address valid, any wait before completion, and back-to-back issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Synchronous clear of the recorded code |
| ld_req | input | 1 | Load request from the compute unit |
| st_req | input | 1 | Store request from the compute unit |
| adr_vld | input | 1 | Address valid |
| adr_val | input | ADDR_W | Address value |
| adr_ack | input | 1 | Address accepted by the buffer |
| adr_exc | input | 1 | Address refused by the buffer |
| ld_done | input | 1 | Load data valid pulse |
| st_strobe | input | 1 | Store data valid pulse |
| busy | input | 1 | Busy as seen on the port |
| err_sticky | output | 1 | Any rule broken since the last clear or reset |
| err_code | output | 10 | One bit per rule, sticky |

## Verification
The assertions assume the clear and reset inputs are the only ways to remove recorded bits. They also assume that a transaction opens only on a request edge seen while idle. For this reason the bench drops the request for at least one cycle between transactions. Every stimulus sequence is built from complete legal transactions with random latency, address timing and gaps, or from one deliberate violation that follows a reset. This keeps each expected code to a single known pattern.

// File: rtl/ldst_mon_pkg.sv
package ldst_mon_pkg;

    localparam int RULE_CNT     = 10;
    localparam int RULE_BOTH    = 0;
    localparam int RULE_OVERLAP = 1;
    localparam int RULE_BUSY    = 2;
    localparam int RULE_HOLD    = 3;
    localparam int RULE_ACK2    = 4;
    localparam int RULE_EXC2    = 5;
    localparam int RULE_ACKEXC  = 6;
    localparam int RULE_STRAY   = 7;
    localparam int RULE_LDD     = 8;
    localparam int RULE_STB     = 9;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_e;

    // tracker view handed to the rule checks
    typedef struct packed {
        logic req_edge;
        logic idle;
        logic open_now;
        op_e  op_now;
        logic ack_seen;
        logic ack_prev;
        logic exc_prev;
        logic ldd_prev;
        logic stb_prev;
        logic addr_drift;
        logic busy_exp;
    } view_t;

endpackage

// File: rtl/ldst_mon_track.sv
module ldst_mon_track
    import ldst_mon_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_req,
    input  logic              st_req,
    input  logic              adr_vld,
    input  logic [ADDR_W-1:0] adr_val,
    input  logic              adr_ack,
    input  logic              adr_exc,
    input  logic              ld_done,
    input  logic              st_strobe,
    output view_t             view
);

    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic              req_prev;
        logic              vld_seen;
        logic              ack_seen;
        logic              ack_prev;
        logic              exc_prev;
        logic              ldd_prev;
        logic              stb_prev;
        logic [ADDR_W-1:0] adr_cap;
    } trk_t;

    trk_t q, d;
    logic req_any, req_edge, idle, open_now, ld_end, exc_end, st_end;
    op_e  op_now;

    always_comb begin
        req_any  = ld_req | st_req;
        req_edge = req_any & ~q.req_prev;
        idle     = (q.phase == PH_IDLE);
        open_now = (idle & req_edge) | (q.phase == PH_OPEN);
        op_now   = idle ? ((st_req && !ld_req) ? OP_STORE : OP_LOAD) : q.op;
        ld_end   = open_now & ld_done & (op_now == OP_LOAD);
        exc_end  = open_now & adr_exc;
        st_end   = open_now & st_strobe & (op_now == OP_STORE) & q.ack_seen;

        d          = q;
        d.req_prev = req_any;
        d.ack_prev = adr_ack;
        d.exc_prev = adr_exc;
        d.ldd_prev = ld_done;
        d.stb_prev = st_strobe;
        if (open_now) begin
            d.op = op_now;
            if (adr_vld && !q.vld_seen) d.adr_cap = adr_val;
            d.vld_seen = q.vld_seen | adr_vld;
            d.ack_seen = q.ack_seen | adr_ack;
            if (ld_end || exc_end)  d.phase = PH_IDLE;
            else if (st_end)        d.phase = PH_TAIL;
            else                    d.phase = PH_OPEN;
            if (ld_end || exc_end || st_end) begin
                d.vld_seen = 1'b0;
                d.ack_seen = 1'b0;
            end
        end else begin
            d.phase    = PH_IDLE;
            d.vld_seen = 1'b0;
            d.ack_seen = 1'b0;
        end

        view.req_edge   = req_edge;
        view.idle       = idle;
        view.open_now   = open_now;
        view.op_now     = op_now;
        view.ack_seen   = q.ack_seen;
        view.ack_prev   = q.ack_prev;
        view.exc_prev   = q.exc_prev;
        view.ldd_prev   = q.ldd_prev;
        view.stb_prev   = q.stb_prev;
        view.addr_drift = (q.phase == PH_OPEN) & q.vld_seen &
                          (~adr_vld | (adr_val != q.adr_cap));
        view.busy_exp   = open_now & ~ld_end & ~exc_end;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R11
    idle_after_rst_chk: assert property (@(posedge clk)
        rst |=> (q.phase == PH_IDLE && !q.ack_seen && !q.vld_seen));

    // R3
    tail_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (q.phase == PH_TAIL) |=> (q.phase == PH_IDLE));

endmodule

// File: rtl/ldst_mon_rules.sv
module ldst_mon_rules
    import ldst_mon_pkg::*;
(
    input  logic                ld_req,
    input  logic                st_req,
    input  logic                adr_ack,
    input  logic                adr_exc,
    input  logic                ld_done,
    input  logic                st_strobe,
    input  logic                busy,
    input  view_t               view,
    output logic [RULE_CNT-1:0] viol
);

    always_comb begin
        viol               = '0;
        viol[RULE_BOTH]    = ld_req & st_req;
        viol[RULE_OVERLAP] = view.req_edge & ~view.idle;
        viol[RULE_BUSY]    = busy ^ view.busy_exp;
        viol[RULE_HOLD]    = view.addr_drift;
        viol[RULE_ACK2]    = adr_ack & view.ack_prev;
        viol[RULE_EXC2]    = adr_exc & view.exc_prev;
        viol[RULE_ACKEXC]  = adr_exc & view.open_now & (view.ack_seen | adr_ack);
        viol[RULE_STRAY]   = (adr_ack | adr_exc) & ~view.open_now;
        viol[RULE_LDD]     = ld_done & (~view.open_now | (view.op_now != OP_LOAD) |
                                        view.ldd_prev);
        viol[RULE_STB]     = st_strobe & (~view.open_now | (view.op_now != OP_STORE) |
                                          ~view.ack_seen | view.stb_prev);
    end

endmodule

// File: rtl/ldst_mon_errlog.sv
module ldst_mon_errlog
    import ldst_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_err,
    input  logic [RULE_CNT-1:0] viol,
    output logic [RULE_CNT-1:0] err_q
);

    typedef struct packed {
        logic [RULE_CNT-1:0] code;
    } log_t;

    log_t q, d;

    always_comb begin
        d.code = (clr_err ? '0 : q.code) | viol;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign err_q = q.code;

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_err |=> ((err_q & $past(err_q)) == $past(err_q)));

    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_err && viol == '0) |=> (err_q == '0));

endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
    import ldst_mon_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_err,
    input  logic                ld_req,
    input  logic                st_req,
    input  logic                adr_vld,
    input  logic [ADDR_W-1:0]   adr_val,
    input  logic                adr_ack,
    input  logic                adr_exc,
    input  logic                ld_done,
    input  logic                st_strobe,
    input  logic                busy,
    output logic                err_sticky,
    output logic [RULE_CNT-1:0] err_code
);

    view_t               view;
    logic [RULE_CNT-1:0] viol;

    ldst_mon_track #(.ADDR_W(ADDR_W)) i_track (
        .clk       (clk),
        .rst       (rst),
        .ld_req    (ld_req),
        .st_req    (st_req),
        .adr_vld   (adr_vld),
        .adr_val   (adr_val),
        .adr_ack   (adr_ack),
        .adr_exc   (adr_exc),
        .ld_done   (ld_done),
        .st_strobe (st_strobe),
        .view      (view)
    );

    ldst_mon_rules i_rules (
        .ld_req    (ld_req),
        .st_req    (st_req),
        .adr_ack   (adr_ack),
        .adr_exc   (adr_exc),
        .ld_done   (ld_done),
        .st_strobe (st_strobe),
        .busy      (busy),
        .view      (view),
        .viol      (viol)
    );

    ldst_mon_errlog i_errlog (
        .clk     (clk),
        .rst     (rst),
        .clr_err (clr_err),
        .viol    (viol),
        .err_q   (err_code)
    );

    assign err_sticky = |err_code;

    // R1
    both_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_req && st_req) |=> err_code[RULE_BOTH]);

    // R3
    busy_match_chk: assert property (@(posedge clk) disable iff (rst)
        (busy != view.busy_exp) |=> err_code[RULE_BUSY]);

    // R5
    ack_twice_chk: assert property (@(posedge clk) disable iff (rst)
        (adr_ack && view.ack_prev) |=> err_code[RULE_ACK2]);

    // R7
    stray_chk: assert property (@(posedge clk) disable iff (rst)
        ((adr_ack || adr_exc) && !view.open_now) |=> err_code[RULE_STRAY]);

    // R11
    rst_empty_chk: assert property (@(posedge clk)
        rst |=> (err_code == '0 && !err_sticky));

endmodule

// File: tb/test_ldst_port_monitor.sv
module test_ldst_port_monitor;
    import ldst_mon_pkg::*;

    localparam int AW = 48;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                clr_err = 1'b0;
    logic                ld_req = 1'b0, st_req = 1'b0, adr_vld = 1'b0;
    logic [AW-1:0]       adr_val = '0;
    logic                adr_ack = 1'b0, adr_exc = 1'b0;
    logic                ld_done = 1'b0, st_strobe = 1'b0, busy = 1'b0;
    logic                err_sticky;
    logic [RULE_CNT-1:0] err_code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ldst_port_monitor #(.ADDR_W(AW)) i_ldst_port_monitor (
        .clk(clk), .rst(rst), .clr_err(clr_err), .ld_req(ld_req), .st_req(st_req),
        .adr_vld(adr_vld), .adr_val(adr_val), .adr_ack(adr_ack), .adr_exc(adr_exc),
        .ld_done(ld_done), .st_strobe(st_strobe), .busy(busy),
        .err_sticky(err_sticky), .err_code(err_code)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        ld_req = 0; st_req = 0; adr_vld = 0; adr_ack = 0; adr_exc = 0;
        ld_done = 0; st_strobe = 0; busy = 0; clr_err = 0;
    endtask

    task automatic do_reset();
        quiet();
        rst = 1; step(); step(); rst = 0;
    endtask

    function automatic logic [RULE_CNT-1:0] bit_of(input int i);
        logic [RULE_CNT-1:0] b = '0;
        b[i] = 1'b1;
        return b;
    endfunction

    task automatic chk(input logic [RULE_CNT-1:0] exp, input string tag);
        n_chk++;
        if (err_code !== exp || err_sticky !== (|exp)) begin
            n_bad++;
            $display("FAIL %s: err_code=%b sticky=%b expected code=%b sticky=%b",
                     tag, err_code, err_sticky, exp, |exp);
        end
    endtask

    function automatic logic [RULE_CNT-1:0] expect_case(input int sel);
        case (sel)
            0:       return bit_of(RULE_BOTH);
            1:       return bit_of(RULE_OVERLAP);
            2,3,4:   return bit_of(RULE_BUSY);
            5,6:     return bit_of(RULE_HOLD);
            7:       return bit_of(RULE_ACK2);
            8:       return bit_of(RULE_EXC2) | bit_of(RULE_STRAY);
            9:       return bit_of(RULE_ACKEXC);
            10:      return bit_of(RULE_STRAY);
            11:      return bit_of(RULE_LDD);
            default: return bit_of(RULE_STB);
        endcase
    endfunction

    function automatic string case_tag(input int sel);
        case (sel)
            0: return "R1 both requests";
            1: return "R2 request edge while open";
            2: return "R3 busy late";
            3: return "R3 busy held in store tail";
            4: return "R3 busy held at load done";
            5: return "R4 address changed";
            6: return "R4 address valid dropped";
            7: return "R5 acknowledge twice";
            8: return "R5 exception twice";
            9: return "R6 exception after acknowledge";
            10: return "R7 acknowledge while idle";
            11: return "R8 load data in store";
            12: return "R9 strobe before acknowledge";
            default: return "R9 strobe in load";
        endcase
    endfunction

    task automatic open_txn(input bit is_st, input logic [AW-1:0] a);
        ld_req = !is_st; st_req = is_st; busy = 1; adr_vld = 1; adr_val = a;
        step();
    endtask

    task automatic run_case(input int sel, input logic [AW-1:0] a);
        case (sel)
            0: begin ld_req = 1; st_req = 1; busy = 1; step(); end           // R1
            1: begin ld_req = 1; busy = 1; step(); ld_req = 0; step();        // R2
                     ld_req = 1; step(); end
            2: begin ld_req = 1; busy = 0; step(); end                        // R3
            3: begin open_txn(1, a); adr_ack = 1; step(); adr_ack = 0;        // R3
                     st_strobe = 1; step(); st_strobe = 0; st_req = 0;
                     adr_vld = 0; step(); end
            4: begin open_txn(0, a); adr_ack = 1; step(); adr_ack = 0;        // R3
                     ld_done = 1; step(); end
            5: begin open_txn(0, a); adr_val = a ^ 48'h1; step(); end         // R4
            6: begin open_txn(0, a); adr_vld = 0; step(); end                 // R4
            7: begin open_txn(0, a); adr_ack = 1; step(); step(); end         // R5
            8: begin open_txn(0, a); adr_exc = 1; busy = 0; step();           // R5
                     ld_req = 0; adr_vld = 0; step(); end
            9: begin open_txn(0, a); adr_ack = 1; step(); adr_ack = 0;        // R6
                     adr_exc = 1; busy = 0; step(); end
            10: begin adr_ack = 1; step(); end                                // R7
            11: begin open_txn(1, a); ld_done = 1; step(); end                // R8
            12: begin open_txn(1, a); st_strobe = 1; step(); end              // R9
            default: begin open_txn(0, a); adr_ack = 1; step(); adr_ack = 0;  // R9
                     st_strobe = 1; step(); end
        endcase
    endtask

    // R12: one compliant transaction; kind 0 load, 1 store, 2 exception
    task automatic legal_txn(input int kind, input int lat, input bit late_vld,
                             input logic [AW-1:0] a);
        ld_req = (kind != 1); st_req = (kind == 1); busy = 1;
        adr_val = a; adr_vld = !late_vld;
        step();
        if (late_vld) begin adr_vld = 1; step(); end
        if (kind == 2) begin
            adr_exc = 1; busy = 0; step(); adr_exc = 0;
        end else begin
            adr_ack = 1; step(); adr_ack = 0;
            for (int w = 0; w < lat; w++) step();
            if (kind == 0) begin
                ld_done = 1; busy = 0; step(); ld_done = 0;
            end else begin
                st_strobe = 1; step(); st_strobe = 0; busy = 0;
                st_req = 0; adr_vld = 0; step();
            end
        end
        ld_req = 0; st_req = 0; adr_vld = 0;
        step();
    endtask

    initial begin
        void'($urandom(32'd1357));
        do_reset();
        chk('0, "R11 reset state");

        // directed violations, one per reset
        for (int s = 0; s < 14; s++) begin
            do_reset();
            run_case(s, 48'h0000_1234_5670);
            chk(expect_case(s), case_tag(s));
        end

        // R10 stickiness and clear
        do_reset();
        adr_ack = 1; step(); adr_ack = 0;
        step(); step(); step();
        chk(bit_of(RULE_STRAY), "R10 sticky across idle cycles");
        clr_err = 1; step(); clr_err = 0;
        chk('0, "R10 clear empties code");
        adr_ack = 1; step(); adr_ack = 0;
        clr_err = 1; ld_req = 1; st_req = 1; busy = 1; step();
        clr_err = 0;
        chk(bit_of(RULE_BOTH), "R10 violation in clear cycle kept");

        // R11 reset forgets errors and an open transaction
        do_reset();
        chk('0, "R11 reset clears code");
        open_txn(0, 48'h42);
        rst = 1; step(); quiet(); step(); rst = 0; step(); step();
        chk('0, "R11 open transaction forgotten");

        // R12 constrained random legal traffic
        do_reset();
        for (int i = 0; i < 60; i++) begin
            legal_txn(int'($urandom % 3), int'($urandom % 4), bit'($urandom % 2),
                      {$urandom, $urandom});
            for (int g = 0; g < int'($urandom % 3); g++) step();
            chk('0, "R12 compliant traffic");
        end

        // random picks of violations with random addresses
        for (int i = 0; i < 12; i++) begin
            int s;
            s = int'($urandom % 14);
            do_reset();
            run_case(s, {$urandom, $urandom} | 48'h2);
            chk(expect_case(s), case_tag(s));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule